// File: doc/BRIEF.md
# Converter Offset Self-Calibration Engine

This engine searches for the offset-trim code that puts a converter's reading of a grounded or selected input just at the point where it becomes zero. For each conversion it drives a trim code to the converter and issues a single conversion request. It then examines whether the returned result is zero. A bisection over the codes 0 to 4096 produces one trial code.

Ten trials are run back to back. The smallest and the largest trial codes are dropped, and the remaining eight are averaged with a fixed rounding rule. The final code is presented together with a one-cycle done pulse.

The engine also handles two things around the search. Each converter unit has its own record of the last trim code written, and a write that would repeat that code is suppressed. When the second unit is calibrated, a request that returns the shared-converter arbiter to its default setup is issued first.

Top module: `offset_cal_engine`

## Requirements
- R1: After reset, `busy`, `done`, `conv_req`, `trim_wr` and `arb_default` are low. A `cal_start` pulse while idle raises `busy` at the next edge and latches `cal_unit`. A `cal_start` pulse while `busy` is high has no effect.
- R2: Every trial starts with a low bound of 0, a high bound of 4096 and a first probe of 2048. Each conversion applies the probe on `trim_code` in the same cycle as a one-cycle `conv_req`. `trim_code` then stays unchanged until `conv_done` arrives.
- R3: A reading is zero only when all 12 bits of `conv_data` are 0. A zero reading moves the high bound down to the probe, and a non-zero reading moves the low bound up to it. The next probe is the integer midpoint of the new bounds.
- R4: Once the bounds differ by exactly 1 and the midpoint conversion has completed, one extra conversion is made at the probe plus 1. That code is the trial's result, so every trial takes exactly 14 conversions. When the reading is zero exactly for codes at or above a threshold T, the trial's result is T limited to the range 1 to 4096.
- R5: A calibration runs exactly 10 trials, which is 140 conversions.
- R6: The result is S − min − max divided by 8, where S is the sum of the ten trial codes. The quotient is increased by 1 when the remainder is 4 or more. The result always lies between 1 and 4096.
- R7: `done` is a one-cycle pulse, and `busy` falls on the same edge. `result` holds its value until the next calibration ends.
- R8: When `cal_unit` is 1, `arb_default` pulses for one cycle before the first `conv_req`. When `cal_unit` is 0, it does not pulse.
- R9: `trim_wr` pulses with a conversion's probe only when the probe differs from the last code written for that unit, which is given on `trim_unit`. After reset, each unit's record holds all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Begin a calibration (sampled while idle) |
| cal_unit | input | UNIT_W | Unit to calibrate |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | CODE_W | Final averaged trim code |
| arb_default | output | 1 | Request to reset the shared arbiter to defaults |
| trim_code | output | CODE_W | Trim code presented to the converter |
| trim_wr | output | 1 | Trim register write strobe |
| trim_unit | output | UNIT_W | Unit addressed by the trim write |
| conv_req | output | 1 | One-conversion request pulse |
| conv_done | input | 1 | Conversion complete |
| conv_data | input | DATA_W | Conversion result |

## Verification
The bench builds the engine with its default parameters: 12-bit data, a 4096-code range, ten trials and a one-bit unit select. With these values, per-trial thresholds of 0 and above 4096 drive the search to both ends of the code range, at 1 and at 4096. Chosen trial sets place the trimmed remainder at exactly 3 and exactly 4, which exercises both sides of the rounding rule. Repeated 2048 results make the first probe of a trial equal the last code written, which exercises the suppressed write.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_APPLY,
    ST_WAIT,
    ST_FINISH
  } cal_state_t;
endpackage

// File: rtl/cal_bisect.sv
module cal_bisect #(
  parameter int CODE_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              step,
  input  logic              is_zero,
  output logic [CODE_W-1:0] probe,
  output logic              extra
);
  localparam logic [CODE_W-1:0] RANGE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] hi_q, lo_q, probe_q;
  logic              extra_q;
  logic [CODE_W-1:0] hi_n, lo_n;
  logic [CODE_W:0]   mid_sum;

  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    if (is_zero) hi_n = probe_q;
    else         lo_n = probe_q;
    mid_sum = {1'b0, hi_n} + {1'b0, lo_n};
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      hi_q    <= RANGE;
      lo_q    <= '0;
      probe_q <= RANGE >> 1;
      extra_q <= 1'b0;
    end else if (step && !extra_q) begin
      if (hi_q - lo_q == CODE_W'(1)) begin
        probe_q <= probe_q + CODE_W'(1);
        extra_q <= 1'b1;
      end else begin
        hi_q    <= hi_n;
        lo_q    <= lo_n;
        probe_q <= mid_sum[CODE_W:1];
      end
    end
  end

  assign probe = probe_q;
  assign extra = extra_q;

  AST_PROBE_INSIDE: assert property (@(posedge clk) disable iff (rst)
    !extra_q |-> (lo_q <= probe_q && probe_q < hi_q)); // R3
  AST_EXTRA_AT_HIGH: assert property (@(posedge clk) disable iff (rst)
    extra_q |-> (probe_q == hi_q)); // R4
  AST_BOUNDS_HALVE: assert property (@(posedge clk) disable iff (rst)
    (step && !extra_q && !init && (hi_q - lo_q > CODE_W'(1)))
      |=> ((hi_q - lo_q) == ($past(hi_q - lo_q) >> 1))); // R3
endmodule

// File: rtl/cal_stats.sv
module cal_stats #(
  parameter int CODE_W = 13,
  parameter int TRIALS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              add,
  input  logic [CODE_W-1:0] code,
  output logic              last,
  output logic [CODE_W-1:0] result
);
  localparam int SUM_W = $clog2(TRIALS * (1 << (CODE_W - 1)) + 1);
  localparam int CNT_W = $clog2(TRIALS + 1);
  localparam int DIV   = TRIALS - 2;
  localparam int HALF  = DIV / 2;

  logic [SUM_W-1:0]  sum_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] min_q, max_q;
  logic [SUM_W-1:0]  trimmed, quot, remd;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sum_q <= '0;
      cnt_q <= '0;
      min_q <= '1;
      max_q <= '0;
    end else if (add) begin
      sum_q <= sum_q + SUM_W'(code);
      cnt_q <= cnt_q + CNT_W'(1);
      if (code < min_q) min_q <= code;
      if (code > max_q) max_q <= code;
    end
  end

  always_comb begin
    trimmed = sum_q - SUM_W'(min_q) - SUM_W'(max_q);
    quot    = trimmed / SUM_W'(DIV);
    remd    = trimmed % SUM_W'(DIV);
    result  = (remd < SUM_W'(HALF)) ? CODE_W'(quot) : CODE_W'(quot + SUM_W'(1));
  end

  assign last = add && (cnt_q == CNT_W'(TRIALS - 1));

  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (min_q <= max_q)); // R6
  AST_TRIAL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(TRIALS)); // R5
endmodule

// File: rtl/cal_trim_port.sv
module cal_trim_port #(
  parameter int CODE_W = 13,
  parameter int UNIT_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apply,
  input  logic [UNIT_W-1:0] unit,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] trim_code,
  output logic              trim_wr,
  output logic [UNIT_W-1:0] trim_unit
);
  localparam int UNITS = 1 << UNIT_W;

  logic [CODE_W-1:0] last_q [UNITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      trim_code <= '0;
      trim_wr   <= 1'b0;
      trim_unit <= '0;
      for (int i = 0; i < UNITS; i++) last_q[i] <= '1;
    end else begin
      trim_wr <= 1'b0;
      if (apply) begin
        trim_code <= code;
        trim_unit <= unit;
        if (code != last_q[unit]) begin
          trim_wr      <= 1'b1;
          last_q[unit] <= code;
        end
      end
    end
  end

  AST_WR_NEEDS_APPLY: assert property (@(posedge clk) disable iff (rst)
    trim_wr |-> $past(apply)); // R9
endmodule

// File: rtl/offset_cal_engine.sv
module offset_cal_engine
  import cal_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int RANGE_LOG2 = 12,
  parameter int CODE_W     = RANGE_LOG2 + 1,
  parameter int TRIALS     = 10,
  parameter int UNIT_W     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_start,
  input  logic [UNIT_W-1:0] cal_unit,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] result,
  output logic              arb_default,
  output logic [CODE_W-1:0] trim_code,
  output logic              trim_wr,
  output logic [UNIT_W-1:0] trim_unit,
  output logic              conv_req,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data
);
  localparam logic [CODE_W-1:0] RANGE = CODE_W'(1) << RANGE_LOG2;

  cal_state_t        st_q;
  logic [UNIT_W-1:0] unit_q;
  logic [CODE_W-1:0] probe;
  logic              extra, step, trial_end, stats_last;
  logic [CODE_W-1:0] stats_result;

  assign step      = (st_q == ST_WAIT) && conv_done;
  assign trial_end = step && extra;

  cal_bisect #(.CODE_W(CODE_W)) bisect_i (
    .clk(clk), .rst(rst), .init(st_q == ST_INIT), .step(step),
    .is_zero(conv_data == '0), .probe(probe), .extra(extra)
  );

  cal_stats #(.CODE_W(CODE_W), .TRIALS(TRIALS)) stats_i (
    .clk(clk), .rst(rst), .clear((st_q == ST_IDLE) && cal_start),
    .add(trial_end), .code(probe), .last(stats_last), .result(stats_result)
  );

  cal_trim_port #(.CODE_W(CODE_W), .UNIT_W(UNIT_W)) trim_i (
    .clk(clk), .rst(rst), .apply(st_q == ST_APPLY), .unit(unit_q), .code(probe),
    .trim_code(trim_code), .trim_wr(trim_wr), .trim_unit(trim_unit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      unit_q      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      result      <= '0;
      arb_default <= 1'b0;
      conv_req    <= 1'b0;
    end else begin
      done        <= 1'b0;
      arb_default <= 1'b0;
      conv_req    <= 1'b0;
      case (st_q)
        ST_IDLE: if (cal_start) begin
          unit_q      <= cal_unit;
          busy        <= 1'b1;
          arb_default <= (cal_unit == UNIT_W'(1));
          st_q        <= ST_INIT;
        end
        ST_INIT:  st_q <= ST_APPLY;
        ST_APPLY: begin
          conv_req <= 1'b1;
          st_q     <= ST_WAIT;
        end
        ST_WAIT: if (conv_done) begin
          if (trial_end) st_q <= stats_last ? ST_FINISH : ST_INIT;
          else           st_q <= ST_APPLY;
        end
        ST_FINISH: begin
          result <= stats_result;
          done   <= 1'b1;
          busy   <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req); // R2
  AST_TRIM_HELD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && $past(st_q) == ST_WAIT) |-> $stable(trim_code)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R7
  AST_ARB_AT_START: assert property (@(posedge clk) disable iff (rst)
    arb_default |-> $rose(busy)); // R8
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (result >= CODE_W'(1) && result <= RANGE)); // R6
endmodule

// File: tb/offset_cal_engine_tb.sv
module offset_cal_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_PER_TRIAL = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cal_start = 1'b0;
  logic [0:0]  cal_unit = '0;
  logic        busy, done, arb_default, trim_wr, conv_req;
  logic [12:0] result, trim_code;
  logic [0:0]  trim_unit;
  logic        conv_done;
  logic [11:0] conv_data;

  int total = 0, bad = 0;
  int thr [10];
  int conv_cnt = 0, arb_cnt = 0, done_cnt = 0, skip_cnt = 0;
  int pend = 0, pend_code = 0, pend_trial = 0;
  int got_result = 0;
  logic [12:0] lastw [2];
  logic cur_unit = 1'b0;
  logic prev_done = 1'b0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  offset_cal_engine dut_i (
    .clk(clk), .rst(rst), .cal_start(cal_start), .cal_unit(cal_unit),
    .busy(busy), .done(done), .result(result), .arb_default(arb_default),
    .trim_code(trim_code), .trim_wr(trim_wr), .trim_unit(trim_unit),
    .conv_req(conv_req), .conv_done(conv_done), .conv_data(conv_data)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int clamp_code(input int t);
    if (t < 1) return 1;
    if (t > 4096) return 4096;
    return t;
  endfunction

  function automatic int expected_result();
    int s = 0, mn = 99999, mx = -1, c, rem;
    for (int i = 0; i < 10; i++) begin
      c = clamp_code(thr[i]);
      s += c;
      if (c < mn) mn = c;
      if (c > mx) mx = c;
    end
    rem = s - mn - mx;
    return (rem % 8 < 4) ? rem / 8 : rem / 8 + 1;
  endfunction

  task automatic respond();
    int t = (pend_trial > 9) ? 9 : pend_trial;
    conv_done = 1'b1;
    conv_data = (pend_code >= thr[t]) ? 12'd0 : 12'(($urandom % 4095) + 1);
  endtask

  // converter model and port monitor
  initial begin
    bit exp_wr;
    conv_done = 1'b0;
    conv_data = '0;
    lastw[0] = '1;
    lastw[1] = '1;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) respond();
      end
      if (!rst && conv_req) begin
        if (conv_cnt % CONV_PER_TRIAL == 0)
          check(trim_code == 13'd2048, "R2 first probe of trial", trim_code, 2048);
        if (conv_cnt == 0)
          check(arb_cnt == int'(cur_unit), "R8 arbiter request before first conversion", arb_cnt, cur_unit);
        exp_wr = (trim_code != lastw[cur_unit]);
        check(trim_wr == exp_wr, "R9 write strobe vs last code", trim_wr, exp_wr);
        check(trim_unit == cur_unit, "R9 trim unit", trim_unit, cur_unit);
        if (exp_wr) lastw[cur_unit] = trim_code;
        else skip_cnt++;
        pend_code  = trim_code;
        pend_trial = conv_cnt / CONV_PER_TRIAL;
        conv_cnt++;
        pend = $urandom % 4;
        if (pend == 0) respond();
      end
      if (arb_default) arb_cnt++;
      if (done) begin
        done_cnt++;
        got_result = result;
        check(!busy, "R7 busy low with done", busy, 0);
      end
      if (done && prev_done) check(0, "R7 done longer than one cycle", 1, 0);
      prev_done = done;
    end
  end

  task automatic run_cal(input logic u, input bit poke, input string tag);
    int exp = expected_result();
    cur_unit = u;
    conv_cnt = 0; arb_cnt = 0; done_cnt = 0; skip_cnt = 0;
    @(negedge clk);
    cal_start = 1'b1; cal_unit = u;
    @(negedge clk);
    cal_start = 1'b0;
    check(busy, {"R1 busy after start ", tag}, busy, 1);
    if (poke) begin
      repeat (60) @(negedge clk);
      cal_start = 1'b1; cal_unit = ~u;
      @(negedge clk);
      cal_start = 1'b0;
    end
    for (int i = 0; i < 4000 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done_cnt == 1, {"R7 single done ", tag}, done_cnt, 1);
    check(got_result == exp, {"R6 result ", tag}, got_result, exp);
    check(result == exp, {"R7 result held ", tag}, result, exp);
    check(conv_cnt == 140, {"R4 R5 conversion count ", tag}, conv_cnt, 140);
    check(arb_cnt == int'(u), {"R8 arbiter pulses ", tag}, arb_cnt, u);
    check(!busy, {"R1 idle after run ", tag}, busy, 0);
  endtask

  initial begin
    int base;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !conv_req && !trim_wr && !arb_default,
          "R1 reset state", {busy, done, conv_req, trim_wr, arb_default}, 0);

    foreach (thr[i]) thr[i] = 0;
    run_cal(1'b0, 0, "low end");
    foreach (thr[i]) thr[i] = 5000;
    run_cal(1'b1, 0, "high end");

    thr = '{100, 500, 500, 500, 900, 500, 500, 504, 500, 500};
    run_cal(1'b0, 0, "round up");
    check(got_result == 501, "R6 remainder four rounds up", got_result, 501);
    thr[7] = 503;
    run_cal(1'b0, 0, "round down");
    check(got_result == 500, "R6 remainder three truncates", got_result, 500);

    foreach (thr[i]) thr[i] = 2048;
    run_cal(1'b1, 0, "repeat code");
    check(skip_cnt >= 9, "R9 repeated code not rewritten", skip_cnt, 9);
    run_cal(1'b1, 0, "repeat code again");
    check(skip_cnt >= 10, "R9 skip persists across runs", skip_cnt, 10);

    foreach (thr[i]) thr[i] = 1234 + i * 3;
    run_cal(1'b0, 1, "start while busy");

    for (int r = 0; r < 8; r++) begin
      base = $urandom % 4300;
      foreach (thr[i]) thr[i] = base + int'($urandom % 41) - 20;
      run_cal(1'($urandom % 2), 0, "random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired, run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule